// File: doc/BRIEF.md
# Video Frame Geometry Monitor

This block sits on a video stream on its way to a frame store and checks that the stream's shape matches the frame size that software has programmed. Each beat carries one 16-bit pixel. A beat with the start-of-frame flag (carried on TUSER) begins a frame, and a beat with TLAST ends a line. The block counts bytes within each line and counts completed lines within each frame. It latches two kinds of mismatch into a status word, and software clears them by writing ones to the error bits.

The stream passes through without change, so the monitor adds no cycles and no buffering. Software programs the line length in bytes, not in pixels: with one 2-byte pixel per beat, an 800-pixel line needs the value 1600. Software also programs the frame height in lines and sets a run bit. A size written by software takes effect at the next start of frame, so the frame in progress keeps the sizes it started with.

Top module: `vid_geom_mon`

## Requirements
- R1: The output stream is the input stream with no change in the same cycle: m_tvalid, m_tdata, m_tuser and m_tlast equal s_tvalid, s_tdata, s_tuser and s_tlast, and s_tready equals m_tready.
- R2: Register map (reads are combinational): 0x30 is the control register, with bit 0 as the run bit. 0xA0 holds the frame height in lines. 0xA4 holds the line length in bytes. Each of these reads back the value last written. A read at any other address returns 0.
- R3: Status is at 0x34. Bit 16 always reads 1. Bit 0 reads 1 while stopped and 0 while running. After reset the status reads 0x10001, and while running with no errors it reads 0x10000.
- R4: A beat is a cycle with s_tvalid and m_tready both high, and each beat counts 2 bytes. A line whose byte total equals the programmed line length, with TLAST on its last beat, raises no error.
- R5: A beat without TLAST that brings the line's byte total to the programmed line length or beyond sets status bit 15 (line end late).
- R6: A start-of-frame beat that arrives after fewer completed lines than the active frame height sets status bit 7 (frame start early). The first start of frame after run is set is not checked.
- R7: Status bit 4 reads 1 exactly when bit 7 or bit 15 is set.
- R8: Writing to 0x34 clears bit 7 and bit 15 where the written data has a 1. A 0 leaves that bit unchanged. If an error occurs in the same cycle as the clearing write, the bit stays set.
- R9: Error bits stay set until software clears them or reset occurs.
- R10: Writes to the size registers take effect at the next start-of-frame beat. The frame in progress keeps the sizes it started with.
- R11: A line that ends early and a frame that has more lines than the programmed height are not flagged.
- R12: While stopped, beats are ignored and no error is set. After run is set again, checking begins at the next start of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready (copy of m_tready) |
| s_tdata | input | DATA_W | Input pixel |
| s_tuser | input | 1 | Input start of frame |
| s_tlast | input | 1 | Input end of line |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | DATA_W | Output pixel |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |

## Verification
The assertions assume that a beat exists only when s_tvalid and m_tready are both high. They also assume that software changes the run bit only by a write to 0x30, and the status bits only by a write to 0x34. A status bit that rises must therefore trace back to a beat while running, and a bit that stays set must trace back to the absence of a clearing write. The stimulus drives every input on the falling edge and holds it for a full cycle. It inserts stall cycles with valid high and ready low, which must not count, and it keeps the programmed line lengths to whole numbers of 2-byte beats. A behavioural model in the bench predicts the status word every cycle that the status address is selected.

// File: rtl/vid_geom_mon.sv
module vid_geom_mon #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int HSIZE_W = 16,
  parameter int VSIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tuser,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tuser,
  output logic              m_tlast
);
  localparam int BPB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_VSIZE = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] A_HSIZE = ADDR_W'(8'hA4);

  logic               run, synced, err_sof, err_eol;
  logic [HSIZE_W-1:0] hsize_reg, hsize_act;
  logic [VSIZE_W-1:0] vsize_reg, vsize_act;
  logic [HSIZE_W:0]   byte_cnt, byte_base, byte_sum, hs_ext;
  logic [VSIZE_W:0]   line_cnt, line_base;
  logic               beat, sof, active, eol_hit, sof_hit, clr_sof, clr_eol;
  logic [31:0]        stat;

  assign m_tvalid = s_tvalid;
  assign m_tdata  = s_tdata;
  assign m_tuser  = s_tuser;
  assign m_tlast  = s_tlast;
  assign s_tready = m_tready;

  assign beat      = s_tvalid & m_tready;
  assign sof       = beat & s_tuser;
  assign active    = run & (synced | s_tuser);
  assign hs_ext    = {1'b0, s_tuser ? hsize_reg : hsize_act};
  assign byte_base = s_tuser ? '0 : byte_cnt;
  assign byte_sum  = byte_base + (HSIZE_W+1)'(BPB);
  assign line_base = s_tuser ? '0 : line_cnt;
  assign eol_hit   = beat & active & ~s_tlast & (byte_sum >= hs_ext);
  assign sof_hit   = sof & run & synced & (line_cnt < {1'b0, vsize_act});
  assign clr_sof   = reg_wr & (reg_addr == A_STAT) & reg_wdata[7];
  assign clr_eol   = reg_wr & (reg_addr == A_STAT) & reg_wdata[15];

  assign stat = {15'd0, 1'b1, err_eol, 7'd0, err_sof, 2'd0,
                 err_sof | err_eol, 3'd0, ~run};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      hsize_reg <= '0;
      vsize_reg <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL)  run       <= reg_wdata[0];
      if (reg_addr == A_HSIZE) hsize_reg <= reg_wdata[HSIZE_W-1:0];
      if (reg_addr == A_VSIZE) vsize_reg <= reg_wdata[VSIZE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced    <= 1'b0;
      hsize_act <= '0;
      vsize_act <= '0;
    end else if (!run) begin
      synced <= 1'b0;
    end else if (sof) begin
      synced    <= 1'b1;
      hsize_act <= hsize_reg;
      vsize_act <= vsize_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      line_cnt <= '0;
    end else if (beat && active) begin
      if (s_tlast)
        byte_cnt <= '0;
      else if (byte_sum > hs_ext)
        byte_cnt <= hs_ext + 1'b1;
      else
        byte_cnt <= byte_sum;
      if (s_tlast && line_base != '1)
        line_cnt <= line_base + 1'b1;
      else
        line_cnt <= line_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_sof <= 1'b0;
      err_eol <= 1'b0;
    end else begin
      err_sof <= sof_hit | (err_sof & ~clr_sof);
      err_eol <= eol_hit | (err_eol & ~clr_eol);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, run};
      A_STAT:  reg_rdata = stat;
      A_VSIZE: reg_rdata = 32'(vsize_reg);
      A_HSIZE: reg_rdata = 32'(hsize_reg);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vid_geom_mon_chk.sv
module vid_geom_mon_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wd0,
  input logic              wd7,
  input logic              wd15,
  input logic              s_tvalid,
  input logic              m_tready,
  input logic              s_tuser,
  input logic              s_tlast,
  input logic              st_halt,
  input logic              st_sof,
  input logic              st_eol
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h34);

  assert_halt_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_CTRL |=> st_halt == !$past(wd0));

  assert_eol_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_eol) |-> $past(s_tvalid && m_tready && !s_tlast && !st_halt));

  assert_sof_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_sof) |-> $past(s_tvalid && m_tready && s_tuser && !st_halt));

  assert_clear_eol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_STAT && wd15 && !(s_tvalid && m_tready)
    |=> !st_eol);

  assert_sticky_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_eol && !(reg_wr && reg_addr == A_STAT && wd15) |=> st_eol);

  assert_sticky_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_sof && !(reg_wr && reg_addr == A_STAT && wd7) |=> st_sof);
endmodule

bind vid_geom_mon vid_geom_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd0(reg_wdata[0]), .wd7(reg_wdata[7]), .wd15(reg_wdata[15]),
  .s_tvalid(s_tvalid), .m_tready(m_tready), .s_tuser(s_tuser),
  .s_tlast(s_tlast), .st_halt(stat[0]), .st_sof(stat[7]), .st_eol(stat[15])
);

// File: tb/test_vid_geom_mon.sv
`timescale 1ns/1ps
module test_vid_geom_mon;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 8'h34;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        s_tvalid = 0, s_tuser = 0, s_tlast = 0, m_tready = 1;
  logic [15:0] s_tdata = 0;
  logic        s_tready, m_tvalid, m_tuser, m_tlast;
  logic [15:0] m_tdata;

  int tests = 0, fails = 0, beat_no = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  vid_geom_mon i_vid_geom_mon (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tuser(s_tuser), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast));

  // behavioural reference
  bit m_run, syn, e7, e15;
  int m_h, m_v, a_h, a_v, nb, nl;

  always @(posedge clk) begin
    bit s7, s15;
    s7 = 0; s15 = 0;
    if (!rst_n) begin
      m_run = 0; syn = 0; e7 = 0; e15 = 0;
      m_h = 0; m_v = 0; a_h = 0; a_v = 0; nb = 0; nl = 0;
    end else begin
      if (s_tvalid && m_tready && m_run) begin
        if (s_tuser) begin
          if (syn && nl < a_v) s7 = 1;
          a_h = m_h; a_v = m_v; syn = 1; nb = 0; nl = 0;
        end
        if (syn) begin
          nb += 2;
          if (!s_tlast && nb >= a_h) s15 = 1;
          if (s_tlast) begin nb = 0; nl++; end
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h30: begin m_run = reg_wdata[0]; if (!m_run) syn = 0; end
          8'h34: begin if (reg_wdata[7]) e7 = 0; if (reg_wdata[15]) e15 = 0; end
          8'hA0: m_v = reg_wdata[12:0];
          8'hA4: m_h = reg_wdata[15:0];
          default: ;
        endcase
      end
      if (s7) e7 = 1;
      if (s15) e15 = 1;
    end
  end

  function automatic logic [31:0] model_stat();
    return 32'h10000 | (32'(e15) << 15) | (32'(e7) << 7)
         | (32'(e7 | e15) << 4) | 32'(!m_run);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_en && reg_addr == 8'h34) check("R7 model status", reg_rdata, model_stat());
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h34;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a; #2;
    check(tag, reg_rdata, exp);
    @(negedge clk); reg_addr = 8'h34;
  endtask

  task automatic stat_is(logic [31:0] exp, string tag);
    #2; check(tag, reg_rdata, exp);
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_tvalid = 0; s_tuser = 0; s_tlast = 0; m_tready = 1;
    end
  endtask

  task automatic send(bit u, bit l);
    beat_no++;
    if (beat_no % 5 == 3) begin
      @(negedge clk); s_tvalid = 1; s_tuser = u; s_tlast = l;
      s_tdata = 16'(beat_no); m_tready = 0;
    end
    @(negedge clk); s_tvalid = 1; s_tuser = u; s_tlast = l;
    s_tdata = 16'(beat_no * 7); m_tready = 1;
    #1;
    check("R1 passthrough", {m_tvalid, m_tuser, m_tlast, s_tready, m_tdata},
          {s_tvalid, s_tuser, s_tlast, m_tready, s_tdata});
  endtask

  task automatic line(int npix, bit first);
    for (int i = 0; i < npix; i++) send(first && i == 0, i == npix - 1);
  endtask

  task automatic frame(int npix, int nlines);
    for (int l = 0; l < nlines; l++) line(npix, l == 0);
    idle();
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1; cmp_en = 1;
    stat_is(32'h10001, "R3 reset status");

    wr(8'hA0, 4); wr(8'hA4, 16); wr(8'h30, 1);
    rd(8'hA0, 4, "R2 vsize readback");
    rd(8'hA4, 16, "R2 hsize readback");
    rd(8'h30, 1, "R2 ctrl readback");
    rd(8'h40, 0, "R2 unmapped read");
    stat_is(32'h10000, "R3 running status");

    frame(8, 4); frame(8, 4); frame(8, 4);
    stat_is(32'h10000, "R4 matching geometry");

    wr(8'hA4, 8);
    frame(8, 4);
    stat_is(32'h18010, "R5 line end late with bit 4 (R7)");
    idle(5);
    stat_is(32'h18010, "R9 sticky");
    wr(8'h34, 32'h80);
    stat_is(32'h18010, "R8 zero leaves bit 15");
    wr(8'h34, 32'h8000);
    stat_is(32'h10000, "R8 one clears bit 15");
    wr(8'hA4, 16);
    frame(8, 4);
    wr(8'h34, 32'hFFFFFFFF);

    wr(8'hA0, 6);
    frame(8, 4); frame(8, 4);
    stat_is(32'h10090, "R6 frame start early");
    wr(8'hA0, 4);
    frame(8, 4);
    wr(8'h34, 32'hFFFFFFFF);
    frame(8, 4);
    stat_is(32'h10000, "R6 clean after fix");

    frame(5, 6); frame(8, 4);
    stat_is(32'h10000, "R11 short lines and tall frame not flagged");

    line(8, 1); wr(8'hA4, 4);
    line(8, 0); line(8, 0); line(8, 0); idle();
    stat_is(32'h10000, "R10 mid-frame size write deferred");
    frame(8, 4);
    stat_is(32'h18010, "R10 new size applied at next frame");
    wr(8'hA4, 16); frame(8, 4);
    wr(8'h34, 32'hFFFFFFFF);
    frame(8, 4);
    stat_is(32'h10000, "R8 cleared after restore");

    wr(8'h30, 0);
    stat_is(32'h10001, "R3 halted bit");
    frame(3, 2); frame(3, 2);
    stat_is(32'h10001, "R12 stopped ignores bad stream");
    wr(8'h30, 1);
    line(3, 0); line(3, 0); idle();
    stat_is(32'h10000, "R12 no check before first start of frame");
    frame(8, 4); frame(8, 4);
    stat_is(32'h10000, "R12 resynchronised");

    wr(8'hA4, 4);
    frame(2, 4);
    send(1, 0);
    @(negedge clk); s_tvalid = 1; s_tuser = 0; s_tlast = 0; m_tready = 1;
    reg_wr = 1; reg_addr = 8'h34; reg_wdata = 32'hFFFFFFFF;
    @(negedge clk); reg_wr = 0; s_tvalid = 0;
    stat_is(32'h18010, "R8 set wins over clear");
    wr(8'h34, 32'hFFFFFFFF);
    stat_is(32'h10000, "R8 final clear");

    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule